// File: doc/BRIEF.md
# Floating-Point Condition Predicate Evaluator

This block decides whether a floating-point conditional predicate holds for the current condition codes. A 6-bit predicate selector and four condition-code flags (negative, zero, infinity, not-a-number) are presented together with a one-cycle strobe. One clock later the block returns three results: the true/false outcome, a flag for an illegal selector, and an unordered-branch exception bit.

The selector folds three controls into one field. A signalling bit picks the variant that reports comparisons against NaN as exceptions. A negation bit mirrors the selector nibble onto one of eight base relations and inverts the outcome. The upper selector values are reserved and illegal. Branch target arithmetic, counter decrements and trap dispatch belong to the surrounding sequencer. The exception bit is meant to be merged into a status register there.

Top module: `fpcc_eval`

## Requirements
- R1: A selector of 0x20 or above sets the illegal output, forces the result low and keeps the exception output low.
- R2: Bit 3 of the selector is a negation: the low nibble is XORed with 0xF to choose the base relation, and the outcome of that relation is inverted. Bit 4 marks the signalling variant and otherwise selects the same relation as the value without it.
- R3: Base relation 0 is never true. Base relation 1 is true exactly when the zero flag is set.
- R4: Base relation 2 (greater) is true when NaN, zero and negative are all clear. Base relation 4 (less) is true when negative is set and NaN and zero are clear.
- R5: Base relation 3 (greater or equal) is true when zero is set, or when NaN and negative are both clear. Base relation 5 (less or equal) is true when zero is set, or when negative is set and NaN is clear.
- R6: Base relation 6 (greater or less) is true when NaN and zero are both clear. Base relation 7 (ordered) is true when NaN is clear.
- R7: The exception output is high exactly when the selector is legal, bit 4 is set and the NaN flag is set, whatever the outcome. With bit 4 clear it is never raised.
- R8: The infinity flag has no effect on any output.
- R9: The outputs change only in the cycle after a strobe. The valid output is high for exactly one cycle per strobe, and without a strobe the outputs keep their values.
- R10: After reset, valid, result, illegal and exception are all low.

Condition-code input bit positions: bit 0 negative, bit 1 zero, bit 2 infinity, bit 3 NaN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eval_stb_i | input | 1 | Evaluate the presented selector this cycle |
| pred_sel_i | input | 6 | Predicate selector |
| ccode_i | input | 4 | Condition codes {nan, inf, zero, neg} |
| eval_vld_o | output | 1 | Result registered from last cycle's strobe |
| cond_true_o | output | 1 | Predicate outcome |
| pred_bad_o | output | 1 | Selector was illegal |
| unord_exc_o | output | 1 | Unordered-branch exception |

## Verification
The assertions assume that the selector and condition codes are settled whenever the strobe is high. They also assume that the condition codes describe a single class, so NaN is not combined with zero. The properties that compare an output to a past input rely only on the strobe cycle's values. The bench drives every input on the falling edge and holds it through the next rising edge. It sweeps all 64 selectors against all 16 flag combinations, including the combinations that no real result produces, so that the decoder is exercised without gaps.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;
  localparam int PRED_W = 6;
  localparam int NIB_W  = 4;
  localparam int BASE_W = 3;
  localparam int CC_W   = 4;
  localparam int SIG_BIT = 4;
  localparam int NEG_SEL_BIT = 3;
  localparam int CC_NEG  = 0;
  localparam int CC_ZERO = 1;
  localparam int CC_INF  = 2;
  localparam int CC_NAN  = 3;

  typedef enum logic [BASE_W-1:0] {
    BT_NEVER = 3'd0,
    BT_EQ    = 3'd1,
    BT_GT    = 3'd2,
    BT_GE    = 3'd3,
    BT_LT    = 3'd4,
    BT_LE    = 3'd5,
    BT_GL    = 3'd6,
    BT_ORD   = 3'd7
  } base_test_e;

  typedef struct packed {
    logic       illegal;
    logic       signalling;
    logic       negate;
    base_test_e base;
  } pred_dec_t;
endpackage

// File: rtl/fpcc_pred_decode.sv
module fpcc_pred_decode
  import fpcc_pkg::*;
(
  input  logic [PRED_W-1:0] pred_i,
  output pred_dec_t         dec_o
);
  logic [NIB_W-1:0]  nib;
  logic [BASE_W-1:0] folded;

  always_comb begin
    nib    = pred_i[NIB_W-1:0];
    folded = nib[BASE_W-1:0] ^ {BASE_W{nib[NEG_SEL_BIT]}};
    dec_o.illegal    = |pred_i[PRED_W-1:SIG_BIT+1];
    dec_o.signalling = pred_i[SIG_BIT];
    dec_o.negate     = nib[NEG_SEL_BIT];
    dec_o.base       = base_test_e'(folded);
  end
endmodule

// File: rtl/fpcc_base_eval.sv
module fpcc_base_eval
  import fpcc_pkg::*;
(
  input  base_test_e      base_i,
  input  logic [CC_W-1:0] cc_i,
  output logic            hit_o
);
  logic neg, zero, nan;
  logic unused_inf;

  assign neg  = cc_i[CC_NEG];
  assign zero = cc_i[CC_ZERO];
  assign nan  = cc_i[CC_NAN];
  assign unused_inf = cc_i[CC_INF];

  always_comb begin
    unique case (base_i)
      BT_NEVER: hit_o = 1'b0;
      BT_EQ:    hit_o = zero;
      BT_GT:    hit_o = ~(nan | zero | neg);
      BT_GE:    hit_o = zero | ~(nan | neg);
      BT_LT:    hit_o = neg & ~nan & ~zero;
      BT_LE:    hit_o = zero | (neg & ~nan);
      BT_GL:    hit_o = ~(nan | zero);
      BT_ORD:   hit_o = ~nan;
      default:  hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fpcc_eval.sv
module fpcc_eval
  import fpcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eval_stb_i,
  input  logic [PRED_W-1:0] pred_sel_i,
  input  logic [CC_W-1:0]   ccode_i,
  output logic              eval_vld_o,
  output logic              cond_true_o,
  output logic              pred_bad_o,
  output logic              unord_exc_o
);
  pred_dec_t dec;
  logic      base_hit;
  logic      true_nxt, bad_nxt, exc_nxt, vld_nxt;
  logic      true_q, bad_q, exc_q, vld_q;

  fpcc_pred_decode u_dec (
    .pred_i (pred_sel_i),
    .dec_o  (dec)
  );

  fpcc_base_eval u_base (
    .base_i (dec.base),
    .cc_i   (ccode_i),
    .hit_o  (base_hit)
  );

  // Next-state: illegal selectors mask both outcome and exception
  always_comb begin
    vld_nxt  = eval_stb_i;
    bad_nxt  = dec.illegal;
    true_nxt = ~dec.illegal & (base_hit ^ dec.negate);
    exc_nxt  = ~dec.illegal & dec.signalling & ccode_i[CC_NAN];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      true_q <= 1'b0;
      bad_q  <= 1'b0;
      exc_q  <= 1'b0;
    end else if (eval_stb_i) begin
      true_q <= true_nxt;
      bad_q  <= bad_nxt;
      exc_q  <= exc_nxt;
    end
  end

  assign eval_vld_o  = vld_q;
  assign cond_true_o = true_q;
  assign pred_bad_o  = bad_q;
  assign unord_exc_o = exc_q;

  assert_illegal_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_stb_i && pred_sel_i >= 6'h20) |=> (pred_bad_o && !cond_true_o && !unord_exc_o));

  assert_always_true_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_stb_i && pred_sel_i[5] == 1'b0 && pred_sel_i[3:0] == 4'hF) |=> cond_true_o);

  assert_never_true_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_stb_i && pred_sel_i[5] == 1'b0 && pred_sel_i[3:0] == 4'h0) |=> !cond_true_o);

  assert_exc_on_nan_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_stb_i && pred_sel_i[5:4] == 2'b01 && ccode_i[CC_NAN]) |=> unord_exc_o);

  assert_no_exc_aware_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_stb_i && !pred_sel_i[4]) |=> !unord_exc_o);

  assert_vld_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eval_stb_i |=> eval_vld_o);

  assert_vld_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_stb_i |=> !eval_vld_o);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_stb_i |=> ($stable(cond_true_o) && $stable(pred_bad_o) && $stable(unord_exc_o)));
endmodule

// File: tb/test_fpcc_eval.sv
module test_fpcc_eval;
  logic       clk;
  logic       rst_n;
  logic       eval_stb_i;
  logic [5:0] pred_sel_i;
  logic [3:0] ccode_i;
  logic       eval_vld_o, cond_true_o, pred_bad_o, unord_exc_o;
  int         n_checks;
  int         n_errors;
  int         cyc;
  bit         done;

  fpcc_eval i_fpcc_eval (
    .clk(clk), .rst_n(rst_n), .eval_stb_i(eval_stb_i),
    .pred_sel_i(pred_sel_i), .ccode_i(ccode_i),
    .eval_vld_o(eval_vld_o), .cond_true_o(cond_true_o),
    .pred_bad_o(pred_bad_o), .unord_exc_o(unord_exc_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%b expected=%b (pred=%h cc=%b)", tag, act, exp, pred_sel_i, ccode_i);
    end
  endtask

  // Reference model from the requirements: cc = {nan, inf, zero, neg}
  function automatic logic ref_true(input logic [5:0] p, input logic [3:0] c);
    logic gt, lt, eq, un, r;
    logic [3:0] n;
    logic [2:0] b;
    if (p >= 6'h20) return 1'b0;
    un = c[3];
    eq = c[1];
    gt = !c[3] && !c[1] && !c[0];
    lt = c[0] && !c[3] && !c[1];
    n  = p[3:0];
    b  = n[3] ? ~n[2:0] : n[2:0];
    case (b)
      3'd0: r = 1'b0;
      3'd1: r = eq;
      3'd2: r = gt;
      3'd3: r = gt || eq;
      3'd4: r = lt;
      3'd5: r = lt || eq;
      3'd6: r = gt || lt;
      default: r = !un;
    endcase
    return n[3] ? !r : r;
  endfunction

  function automatic string tag_for(input logic [5:0] p);
    logic [2:0] b;
    b = p[3] ? ~p[2:0] : p[2:0];
    case (b)
      3'd0, 3'd1: return "R3";
      3'd2, 3'd4: return "R4";
      3'd3, 3'd5: return "R5";
      default:    return "R6";
    endcase
  endfunction

  task automatic apply(input logic [5:0] p, input logic [3:0] c);
    @(negedge clk);
    eval_stb_i = 1'b1;
    pred_sel_i = p;
    ccode_i    = c;
    @(negedge clk);
    eval_stb_i = 1'b0;
  endtask

  task automatic t_reset;
    // R10
    chk("R10 vld", eval_vld_o, 1'b0);
    chk("R10 true", cond_true_o, 1'b0);
    chk("R10 bad", pred_bad_o, 1'b0);
    chk("R10 exc", unord_exc_o, 1'b0);
  endtask

  task automatic t_sweep;
    // R2 R3 R4 R5 R6 R7: every legal selector, every flag set
    for (int p = 0; p < 32; p++) begin
      for (int c = 0; c < 16; c++) begin
        apply(6'(p), 4'(c));
        chk(tag_for(6'(p)), cond_true_o, ref_true(6'(p), 4'(c)));
        chk("R7", unord_exc_o, (p >= 16) && c[3]);
        chk("R1 legal", pred_bad_o, 1'b0);
        chk("R9 vld", eval_vld_o, 1'b1);
      end
    end
  endtask

  task automatic t_signalling_twin;
    // R2: bit 4 does not change the outcome
    for (int p = 0; p < 16; p++) begin
      apply(6'(p), 4'b0001);
      begin
        logic a = cond_true_o;
        apply(6'(p + 16), 4'b0001);
        chk("R2 twin", cond_true_o, a);
      end
    end
  endtask

  task automatic t_illegal;
    // R1
    for (int p = 32; p < 64; p++) begin
      apply(6'(p), 4'b1000);
      chk("R1 bad", pred_bad_o, 1'b1);
      chk("R1 true", cond_true_o, 1'b0);
      chk("R1 exc", unord_exc_o, 1'b0);
    end
  endtask

  task automatic t_inf_ignored;
    // R8: toggling the infinity flag leaves every output unchanged
    for (int p = 0; p < 64; p++) begin
      for (int c = 0; c < 16; c++) begin
        if (c[2]) continue;
        apply(6'(p), 4'(c));
        begin
          logic t0 = cond_true_o, b0 = pred_bad_o, e0 = unord_exc_o;
          apply(6'(p), 4'(c | 4));
          chk("R8 true", cond_true_o, t0);
          chk("R8 bad", pred_bad_o, b0);
          chk("R8 exc", unord_exc_o, e0);
        end
      end
    end
  endtask

  task automatic t_hold;
    // R9: after one strobe, inputs move without strobe and outputs hold
    apply(6'h1F, 4'b1000);
    chk("R9 t", cond_true_o, 1'b1);
    chk("R9 e", unord_exc_o, 1'b1);
    @(negedge clk);
    pred_sel_i = 6'h30;
    ccode_i    = 4'b0010;
    @(negedge clk);
    chk("R9 vld low", eval_vld_o, 1'b0);
    chk("R9 hold t", cond_true_o, 1'b1);
    chk("R9 hold e", unord_exc_o, 1'b1);
    chk("R9 hold b", pred_bad_o, 1'b0);
  endtask

  task automatic t_back_to_back;
    // R9: consecutive strobes give consecutive results
    @(negedge clk);
    eval_stb_i = 1'b1; pred_sel_i = 6'h01; ccode_i = 4'b0010;
    @(negedge clk);
    chk("R9 b2b vld1", eval_vld_o, 1'b1);
    chk("R3 b2b eq", cond_true_o, 1'b1);
    pred_sel_i = 6'h02; ccode_i = 4'b0001;
    @(negedge clk);
    eval_stb_i = 1'b0;
    chk("R9 b2b vld2", eval_vld_o, 1'b1);
    chk("R4 b2b gt", cond_true_o, 1'b0);
    @(negedge clk);
    chk("R9 b2b idle", eval_vld_o, 1'b0);
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    n_checks = 0; n_errors = 0; cyc = 0; done = 1'b0;
    rst_n = 1'b0; eval_stb_i = 1'b0; pred_sel_i = '0; ccode_i = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sweep();
    t_signalling_twin();
    t_illegal();
    t_inf_ignored();
    t_hold();
    t_back_to_back();
    done = 1'b1;
    finish_run();
  end
endmodule